// File: doc/BRIEF.md
# Sequence-Unlocked Configuration Register Window

This block sits between a host and the byte-addressed command-register port of a disk interface controller. In normal operation it passes every host access straight through to the task-file register file. It also watches the stream of accesses for a short unlock pattern. The pattern is two back-to-back 16-bit reads of command offset 1, followed by a byte write of 0x03 to command offset 2. After the pattern completes, later accesses no longer reach the task file. They go to a small hidden bank of configuration registers instead.

The hidden bank holds the following registers:

- Read-cycle timing.
- Write-cycle timing.
- A control register, which switches the interface on with 0x95 and off with 0x11.
- A strap register that reports the bus clock rate from an input pin.
- A miscellaneous register with seven writable bits.

A byte write of 0x83 to offset 2 closes the window and makes the task file visible again. The state machine has four states:

- `ST_IDLE`: no progress.
- `ST_ONE`: one wide read of offset 1 seen.
- `ST_TWO`: two back-to-back wide reads seen.
- `ST_OPEN`: window unlocked.

It has six named transitions:

- `first_key` (IDLE to ONE).
- `second_key` (ONE to TWO, or TWO to TWO on a further key read).
- `open_key` (TWO to OPEN).
- `restart` (ONE or TWO to ONE is not used; a key read always advances to TWO).
- `break` (ONE or TWO to IDLE on any other access).
- `close_key` (OPEN to IDLE).

Top module: `cfgwin_top`

## Requirements
- R1: The window opens only after two consecutive accesses that are 16-bit reads (`host_wide`=1) of offset 1, immediately followed by a byte write (`host_wide`=0) of low byte 0x03 to offset 2. `window_open` is high from the clock edge that takes that write.
- R2: Any access that does not continue the pattern returns the detector to idle. This covers a wrong offset, a wrong size, a wrong value, or a write where a read is due. A 16-bit read of offset 1 made while one or two key reads are already held counts as the newest key read, so the last two reads form the pair. Cycles without a strobe do not disturb progress.
- R3: While the window is closed, every access is forwarded unchanged to the task-file port, including the accesses that form the pattern: strobes, offset, size and write data. Reads return `tf_rdata`. While the window is open, `tf_rd` and `tf_wr` stay low.
- R4: While the window is open, hidden offsets 0, 1, 3 and 6 hold read timing, write timing, control and miscellaneous. Writes store the low byte of `host_wdata`, for both byte and 16-bit accesses. Reads return the byte zero-extended to 16 bits.
- R5: Hidden offset 5 is the strap register. Bit 0 reads the `strap_slow` input (0 means 33 MHz, 1 means 25 MHz), bits 7:1 read zero, and host writes to it have no effect.
- R6: Only bits 6:0 of the miscellaneous register are writable. Bit 7 always reads 0.
- R7: A write of 0x95 to the control register sets `iface_on` from the next cycle. A write of 0x11 clears it. Any other value is stored but leaves `iface_on` unchanged.
- R8: While the window is open, offsets 2 (apart from the closing write), 4 and 7 read 0x0000, and writes to them change nothing.
- R9: While the window is open, a byte write of 0x83 to offset 2 closes it. That write is not forwarded, and the next access goes to the task file. The hidden registers keep their contents.
- R10: Reset leaves the window closed, `iface_on` low, and all hidden registers at zero except the strap register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_ofs | input | 3 | Host command-register offset |
| host_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data returned to the host |
| tf_ofs | output | 3 | Offset forwarded to the task file |
| tf_wide | output | 1 | Access size forwarded to the task file |
| tf_rd | output | 1 | Forwarded read strobe |
| tf_wr | output | 1 | Forwarded write strobe |
| tf_wdata | output | 16 | Forwarded write data |
| tf_rdata | input | 16 | Read data from the task file |
| strap_slow | input | 1 | Bus clock strap: 1 = 25 MHz, 0 = 33 MHz |
| window_open | output | 1 | High while hidden registers are mapped |
| iface_on | output | 1 | Interface enable set by the control register |

## Verification
A detector stuck in the wrong state shows on the very next access. Either the task-file strobes appear while they should be blocked, or they vanish while they should pass, and the read data comes from the wrong source on the same cycle. A corrupted hidden register shows only when it is read back or, for control, through `iface_on` one cycle after the write. For that reason the random stimulus mixes frequent hidden-register reads with the writes. Each step of the pattern is also broken deliberately by size, offset, value and direction, so a bad transition shows on the following access.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2,
        ST_OPEN = 2'd3
    } win_state_t;

    localparam int BYTE_W    = 8;

    // Pattern offsets and key bytes
    localparam int KEY_OFS   = 1;
    localparam int GATE_OFS  = 2;
    localparam logic [BYTE_W-1:0] OPEN_KEY  = 8'h03;
    localparam logic [BYTE_W-1:0] CLOSE_KEY = 8'h83;

    // Hidden bank map
    localparam int HID_RTIM  = 0;
    localparam int HID_WTIM  = 1;
    localparam int HID_CTRL  = 3;
    localparam int HID_STRAP = 5;
    localparam int HID_MISC  = 6;

    localparam logic [BYTE_W-1:0] CTRL_ON   = 8'h95;
    localparam logic [BYTE_W-1:0] CTRL_OFF  = 8'h11;
    localparam logic [BYTE_W-1:0] MISC_MASK = 8'h7F;

endpackage

// File: rtl/cfgwin_seq.sv
module cfgwin_seq
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    host_ofs,
    input  logic                 host_wide,
    input  logic                 host_rd,
    input  logic                 host_wr,
    input  logic [BYTE_W-1:0]    host_wbyte,
    output logic                 win_open
);

    win_state_t state_q, state_d;

    logic any_acc;
    logic key_rd;
    logic open_wr;
    logic close_wr;

    always_comb begin
        any_acc  = host_rd | host_wr;
        key_rd   = host_rd && host_wide && (host_ofs == ADDR_W'(KEY_OFS));
        open_wr  = host_wr && !host_wide && (host_ofs == ADDR_W'(GATE_OFS))
                   && (host_wbyte == OPEN_KEY);
        close_wr = host_wr && !host_wide && (host_ofs == ADDR_W'(GATE_OFS))
                   && (host_wbyte == CLOSE_KEY);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (key_rd) state_d = ST_ONE;                 // first_key
            end
            ST_ONE: begin
                if (key_rd)       state_d = ST_TWO;           // second_key
                else if (any_acc) state_d = ST_IDLE;          // break
            end
            ST_TWO: begin
                if (open_wr)      state_d = ST_OPEN;          // open_key
                else if (key_rd)  state_d = ST_TWO;           // second_key (slide)
                else if (any_acc) state_d = ST_IDLE;          // break
            end
            ST_OPEN: begin
                if (close_wr) state_d = ST_IDLE;              // close_key
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        win_open = (state_q == ST_OPEN);
    end

    a_r1_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_open) |-> $past(host_wr && !host_wide
            && host_ofs == ADDR_W'(GATE_OFS) && host_wbyte == OPEN_KEY));

    a_r9_close_on_key: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && host_wr && !host_wide && host_ofs == ADDR_W'(GATE_OFS)
         && host_wbyte == CLOSE_KEY) |=> !win_open);

    a_r2_break_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && any_acc && !key_rd && !open_wr) |=> !win_open);

endmodule

// File: rtl/cfgwin_bank.sv
module cfgwin_bank
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    ofs,
    input  logic [BYTE_W-1:0]    wbyte,
    input  logic                 strap_slow,
    output logic [BYTE_W-1:0]    rbyte,
    output logic                 iface_on
);

    logic [BYTE_W-1:0] rtim_q, wtim_q, ctrl_q, misc_q;
    logic              on_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rtim_q <= '0;
            wtim_q <= '0;
            ctrl_q <= '0;
            misc_q <= '0;
            on_q   <= 1'b0;
        end else if (wr_en) begin
            if (ofs == ADDR_W'(HID_RTIM)) rtim_q <= wbyte;
            if (ofs == ADDR_W'(HID_WTIM)) wtim_q <= wbyte;
            if (ofs == ADDR_W'(HID_MISC)) misc_q <= wbyte & MISC_MASK;
            if (ofs == ADDR_W'(HID_CTRL)) begin
                ctrl_q <= wbyte;
                if (wbyte == CTRL_ON)       on_q <= 1'b1;
                else if (wbyte == CTRL_OFF) on_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rbyte = '0;
        if (ofs == ADDR_W'(HID_RTIM))  rbyte = rtim_q;
        if (ofs == ADDR_W'(HID_WTIM))  rbyte = wtim_q;
        if (ofs == ADDR_W'(HID_CTRL))  rbyte = ctrl_q;
        if (ofs == ADDR_W'(HID_STRAP)) rbyte = {{(BYTE_W-1){1'b0}}, strap_slow};
        if (ofs == ADDR_W'(HID_MISC))  rbyte = misc_q;
        iface_on = on_q;
    end

    a_r7_ctrl_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == ADDR_W'(HID_CTRL) && wbyte == CTRL_ON) |=> iface_on);

    a_r7_ctrl_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == ADDR_W'(HID_CTRL) && wbyte == CTRL_OFF) |=> !iface_on);

    a_r6_misc_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs == ADDR_W'(HID_MISC)) |-> !rbyte[BYTE_W-1]);

    a_r5_strap_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ofs == ADDR_W'(HID_STRAP)) |=> $stable(rtim_q) && $stable(wtim_q)
            && $stable(ctrl_q) && $stable(misc_q));

endmodule

// File: rtl/cfgwin_top.sv
module cfgwin_top
    import cfgwin_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    host_ofs,
    input  logic                 host_wide,
    input  logic                 host_rd,
    input  logic                 host_wr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic [ADDR_W-1:0]    tf_ofs,
    output logic                 tf_wide,
    output logic                 tf_rd,
    output logic                 tf_wr,
    output logic [DATA_W-1:0]    tf_wdata,
    input  logic [DATA_W-1:0]    tf_rdata,
    input  logic                 strap_slow,
    output logic                 window_open,
    output logic                 iface_on
);

    localparam int PAD_W = DATA_W - BYTE_W;

    logic              win_open;
    logic [BYTE_W-1:0] hid_rbyte;

    cfgwin_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_ofs   (host_ofs),
        .host_wide  (host_wide),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_wbyte (host_wdata[BYTE_W-1:0]),
        .win_open   (win_open)
    );

    cfgwin_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr && win_open),
        .ofs        (host_ofs),
        .wbyte      (host_wdata[BYTE_W-1:0]),
        .strap_slow (strap_slow),
        .rbyte      (hid_rbyte),
        .iface_on   (iface_on)
    );

    always_comb begin
        tf_ofs      = host_ofs;
        tf_wide     = host_wide;
        tf_wdata    = host_wdata;
        tf_rd       = host_rd && !win_open;
        tf_wr       = host_wr && !win_open;
        host_rdata  = win_open ? {{PAD_W{1'b0}}, hid_rbyte} : tf_rdata;
        window_open = win_open;
    end

    a_r3_blocked_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        window_open |-> !tf_rd && !tf_wr);

    a_r3_forward_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_open && (host_rd || host_wr)) |-> (tf_rd == host_rd) && (tf_wr == host_wr));

endmodule

// File: tb/sim_cfgwin_top.sv
module sim_cfgwin_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_ofs = '0;
    logic        host_wide = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [2:0]  tf_ofs;
    logic        tf_wide, tf_rd, tf_wr;
    logic [15:0] tf_wdata;
    logic [15:0] tf_rdata;
    logic        strap_slow = 1'b0;
    logic        window_open, iface_on;

    int n_checks = 0;
    int n_errors = 0;

    // bench model
    int         ms = 0;          // 0 idle, 1 one, 2 two, 3 open
    logic [7:0] m_rt = 0, m_wt = 0, m_ctrl = 0, m_misc = 0;
    logic       m_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] stub_val(input logic [2:0] o);
        return {4'hB, 1'b0, o, 8'h3C};
    endfunction

    assign tf_rdata = stub_val(tf_ofs);

    cfgwin_top u0 (
        .clk(clk), .rst_n(rst_n), .host_ofs(host_ofs), .host_wide(host_wide),
        .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .tf_ofs(tf_ofs), .tf_wide(tf_wide),
        .tf_rd(tf_rd), .tf_wr(tf_wr), .tf_wdata(tf_wdata), .tf_rdata(tf_rdata),
        .strap_slow(strap_slow), .window_open(window_open), .iface_on(iface_on)
    );

    function automatic logic [15:0] hid_val(input logic [2:0] o);
        case (o)
            3'd0: return {8'h00, m_rt};
            3'd1: return {8'h00, m_wt};
            3'd3: return {8'h00, m_ctrl};
            3'd5: return {15'h0, strap_slow};
            3'd6: return {8'h00, m_misc};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd5: return "R5";
            3'd6: return "R6";
            3'd0, 3'd1, 3'd3: return "R4";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_step(input bit wr, input bit wide, input logic [2:0] o,
                              input logic [15:0] d);
        bit key_rd, open_wr, close_wr;
        key_rd   = !wr && wide && o == 3'd1;
        open_wr  = wr && !wide && o == 3'd2 && d[7:0] == 8'h03;
        close_wr = wr && !wide && o == 3'd2 && d[7:0] == 8'h83;
        case (ms)
            0: ms = key_rd ? 1 : 0;
            1: ms = key_rd ? 2 : 0;
            2: ms = open_wr ? 3 : (key_rd ? 2 : 0);
            default: begin
                if (wr) begin
                    case (o)
                        3'd0: m_rt = d[7:0];
                        3'd1: m_wt = d[7:0];
                        3'd6: m_misc = d[7:0] & 8'h7F;
                        3'd3: begin
                            m_ctrl = d[7:0];
                            if (d[7:0] == 8'h95) m_on = 1'b1;
                            else if (d[7:0] == 8'h11) m_on = 1'b0;
                        end
                        default: ;
                    endcase
                end
                if (close_wr) ms = 0;
            end
        endcase
    endtask

    // one access: drive at negedge, check before the edge, update model after
    task automatic acc(input bit wr, input bit wide, input logic [2:0] o,
                       input logic [15:0] d, input string wtag);
        @(negedge clk);
        host_ofs = o; host_wide = wide; host_rd = !wr; host_wr = wr; host_wdata = d;
        #2;
        chk({wtag, " window_open"}, {15'h0, window_open}, {15'h0, ms == 3});
        chk("R7 iface_on", {15'h0, iface_on}, {15'h0, m_on});
        if (ms == 3) begin
            chk("R3 strobes blocked", {14'h0, tf_rd, tf_wr}, 16'h0);
            if (!wr) chk(tag_of(o), host_rdata, hid_val(o));
        end else begin
            chk("R3 strobes forwarded", {14'h0, tf_rd, tf_wr}, {14'h0, !wr, wr});
            chk("R3 forwarded fields", {tf_wdata[11:0], tf_ofs, tf_wide}, {d[11:0], o, wide});
            if (!wr) chk("R3 task-file data", host_rdata, stub_val(o));
        end
        @(posedge clk);
        model_step(wr, wide, o, d);
        #1;
        host_rd = 1'b0; host_wr = 1'b0;
    endtask

    task automatic unlock(input string tg);
        acc(0, 1, 3'd1, 16'h0, tg);
        acc(0, 1, 3'd1, 16'h0, tg);
        acc(1, 0, 3'd2, 16'h0003, tg);
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset window", {15'h0, window_open}, 16'h0);
        chk("R10 reset iface", {15'h0, iface_on}, 16'h0);

        // R1 unlock, then R10 hidden regs zero
        unlock("R1");
        acc(0, 0, 3'd0, 0, "R1");
        chk("R1 open after pattern", {15'h0, window_open}, 16'h1);
        for (int i = 0; i < 8; i++) acc(0, 0, 3'(i), 0, "R10");
        // R5 strap
        strap_slow = 1'b1;
        acc(0, 0, 3'd5, 0, "R5");
        acc(1, 0, 3'd5, 16'h00FE, "R5");
        strap_slow = 1'b0;
        acc(0, 0, 3'd5, 0, "R5");
        // R4 / R6
        acc(1, 0, 3'd0, 16'h1234, "R4");
        acc(1, 1, 3'd1, 16'hABCD, "R4");
        acc(1, 0, 3'd6, 16'h00FF, "R6");
        acc(0, 0, 3'd6, 0, "R6");
        acc(0, 1, 3'd0, 0, "R4");
        acc(0, 0, 3'd1, 0, "R4");
        // R7 control
        acc(1, 0, 3'd3, 16'h0095, "R7");
        acc(1, 0, 3'd3, 16'h0042, "R7");
        acc(1, 0, 3'd3, 16'h0011, "R7");
        acc(1, 0, 3'd3, 16'h0095, "R7");
        // R8 unmapped
        acc(1, 0, 3'd4, 16'h00AA, "R8");
        acc(1, 1, 3'd2, 16'h0083, "R8");
        acc(1, 0, 3'd2, 16'h0055, "R8");
        acc(0, 0, 3'd4, 0, "R8");
        acc(0, 0, 3'd7, 0, "R8");
        // R9 relock, then contents kept
        acc(1, 0, 3'd2, 16'h0083, "R9");
        acc(0, 0, 3'd0, 0, "R9");
        unlock("R9");
        acc(0, 0, 3'd0, 0, "R9");
        acc(1, 0, 3'd2, 16'h0083, "R9");

        // R2 broken patterns
        acc(0, 1, 3'd1, 0, "R2"); acc(0, 0, 3'd1, 0, "R2"); acc(1, 0, 3'd2, 16'h3, "R2");
        acc(0, 1, 3'd1, 0, "R2"); acc(0, 1, 3'd1, 0, "R2"); acc(1, 1, 3'd2, 16'h3, "R2");
        acc(0, 1, 3'd1, 0, "R2"); acc(0, 1, 3'd1, 0, "R2"); acc(1, 0, 3'd2, 16'h4, "R2");
        acc(0, 1, 3'd1, 0, "R2"); acc(1, 1, 3'd1, 0, "R2"); acc(0, 1, 3'd1, 0, "R2");
        acc(1, 0, 3'd2, 16'h3, "R2");
        acc(0, 1, 3'd1, 0, "R2"); acc(0, 1, 3'd3, 0, "R2"); acc(0, 1, 3'd1, 0, "R2");
        acc(1, 0, 3'd2, 16'h3, "R2");
        // sliding pair: three key reads then key write opens
        acc(0, 1, 3'd1, 0, "R2"); acc(0, 1, 3'd1, 0, "R2"); acc(0, 1, 3'd1, 0, "R2");
        acc(1, 0, 3'd2, 16'h3, "R2");
        acc(0, 0, 3'd3, 0, "R2");
        acc(1, 0, 3'd2, 16'h0083, "R9");

        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 10);
            if ($urandom % 16 == 0) strap_slow = ~strap_slow;
            if (r < 4) acc(0, 1, 3'd1, 0, "R2");
            else if (r < 6) begin
                int k;
                k = int'($urandom % 3);
                acc(1, 0, 3'd2, (k == 0) ? 16'h0003 : (k == 1) ? 16'h0083 : 16'($urandom),
                    "R9");
            end else if (r < 7) begin
                int k;
                k = int'($urandom % 3);
                acc(1, bit'($urandom), 3'd3,
                    (k == 0) ? 16'h0095 : (k == 1) ? 16'h0011 : 16'($urandom), "R7");
            end else
                acc(bit'($urandom), bit'($urandom), 3'($urandom), 16'($urandom), "R3");
        end
        report();
    end

endmodule